// File: doc/BRIEF.md
# Keyed-Unlock Flash Control Registers

This block is the register front end of an embedded flash controller. It holds a program/erase control word and a status word, and it decides when software may touch the bits that start writes and erases. Three lock bits guard the control word. Each lock is opened only by writing a fixed pair of 32-bit key words, in the right order, to its own key register. The program-memory key is honoured only after the control-word lock has been opened. Any lock can be closed again at once by writing a 1 to it.

Software reaches the block over a plain 32-bit register bus with a byte address, write data, and write and read strobes. Read data comes back one cycle after the read strobe. The flash array sequencer drives the busy and ready levels and single-cycle event pulses into the status word. A key sequence that goes wrong ends in a sticky fault. That sequence's lock stays closed until the next reset, and a fault output is raised for the system.

Top module: `flash_keyreg_top`

## Requirements
- R1: After reset, control-word bits 0, 1 and 2 (the control lock, the program lock and the option lock) read as 1. All other control bits read as 0, the status word reads 0 and `key_fault` is 0.
- R2: Control bit 0 clears only after 0x89ABCDEF and then 0x02030405 are written, in that order, to byte offset 0x08. The control word sits at offset 0x04.
- R3: Control bit 1 clears only after 0x8C9DAEBF and then 0x13141516 are written to offset 0x10 while bit 0 is already clear. A program key written while bit 0 is set counts as a bad sequence.
- R4: Control bit 2 clears only after 0xFBEAD9C8 and then 0x24252627 are written to offset 0x14.
- R5: A wrong key value, or a second key written first, sets `key_fault`. The fault stays set, and the lock of that sequence stays set until reset, even if the correct pair is written later.
- R6: Writing 1 to a lock bit at offset 0x04 sets that lock in the same write. Writing 0 to a lock bit has no effect. A relocked lock can be opened again with its key pair.
- R7: Control bits 4 (data-memory select) and 8 (fixed-time write) take written values only while bit 0 is clear. Bits 3 (program enable), 9 (erase) and 10 (half-page program) take written values only while both bit 0 and bit 1 are clear. Otherwise writes to these bits are ignored.
- R8: The status word sits at offset 0x18. Bit 0 (busy) and bit 3 (ready) follow the sequencer levels one cycle late. Bit 1 (end of operation), bit 8 (write-protect error), bit 9 (alignment error) and bit 10 (size error) are sticky. Each is set by its event pulse and cleared by writing 1 to it. A set event wins over a clear in the same cycle.
- R9: Read data appears on the cycle after the read strobe and is 0 on a cycle with no read. Key offsets and unmapped offsets read 0.
- R10: A key word written to a key register whose lock is already clear is ignored: it neither changes any lock nor sets `key_fault`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| seq_busy | input | 1 | Sequencer busy level |
| seq_ready | input | 1 | Sequencer ready level |
| seq_eop | input | 1 | End-of-operation pulse |
| seq_wrperr | input | 1 | Write-protection error pulse |
| seq_pgaerr | input | 1 | Alignment error pulse |
| seq_sizerr | input | 1 | Size error pulse |
| lock_ctl | output | 1 | Control-word lock |
| lock_prog | output | 1 | Program-memory lock |
| lock_opt | output | 1 | Option lock |
| ctl_prg_en | output | 1 | Program enable |
| ctl_data_sel | output | 1 | Data-memory select |
| ctl_fixed_time | output | 1 | Fixed-time write |
| ctl_erase | output | 1 | Erase select |
| ctl_half_page | output | 1 | Half-page program |
| key_fault | output | 1 | Sticky bad-key-sequence flag |

## Verification
A key sequencer stuck in the wrong state shows up at the very next read of offset 0x04: a lock that should have opened still reads 1, or `key_fault` rises on a key write that should have been accepted. A guard that decodes the wrong lock is visible one read after a write to the control word, because the guarded bit either moves when it should hold or holds when it should move. Sticky status flags that fail to hold or fail to clear show on the first status read after the pulse or the write-one-to-clear.

// File: rtl/flash_keyreg_pkg.sv
package flash_keyreg_pkg;

  localparam int NUM_LOCKS = 3;
  localparam int LK_CTL  = 0;
  localparam int LK_PROG = 1;
  localparam int LK_OPT  = 2;

  // byte offsets of the register words
  localparam logic [7:0] OFF_CTRL = 8'h04;
  localparam logic [7:0] OFF_STAT = 8'h18;
  localparam logic [7:0] KEY_OFF [NUM_LOCKS] = '{8'h08, 8'h10, 8'h14};

  // first and second key word for each lock
  localparam logic [31:0] KEY_FIRST  [NUM_LOCKS] = '{32'h89ABCDEF, 32'h8C9DAEBF, 32'hFBEAD9C8};
  localparam logic [31:0] KEY_SECOND [NUM_LOCKS] = '{32'h02030405, 32'h13141516, 32'h24252627};

  // control word bit positions
  localparam int CB_PRG_EN   = 3;
  localparam int CB_DATA_SEL = 4;
  localparam int CB_FIXED    = 8;
  localparam int CB_ERASE    = 9;
  localparam int CB_HALF     = 10;

  // status word bit positions
  localparam int SB_BUSY   = 0;
  localparam int SB_EOP    = 1;
  localparam int SB_READY  = 3;
  localparam int SB_WRPERR = 8;
  localparam int SB_PGAERR = 9;
  localparam int SB_SIZERR = 10;

  typedef enum logic [1:0] {
    KS_IDLE = 2'd0,
    KS_HALF = 2'd1,
    KS_DEAD = 2'd2
  } key_state_e;

  typedef struct packed {
    logic half_page;
    logic erase;
    logic fixed_time;
    logic data_sel;
    logic prg_en;
  } ctl_bits_t;

endpackage

// File: rtl/flash_key_seq.sv
module flash_key_seq
  import flash_keyreg_pkg::*;
#(
  parameter logic [31:0] KEY_A = 32'h0,
  parameter logic [31:0] KEY_B = 32'h0
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        key_we,
  input  logic [31:0] key_data,
  input  logic        allow,
  input  logic        relock,
  output logic        lock,
  output logic        fault
);

  key_state_e st;

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= KS_IDLE;
      lock <= 1'b1;
    end else if (relock) begin
      lock <= 1'b1;
      if (st != KS_DEAD) st <= KS_IDLE;
    end else if (key_we && lock && st != KS_DEAD) begin
      if (!allow) begin
        st <= KS_DEAD;
      end else if (st == KS_IDLE) begin
        st <= (key_data == KEY_A) ? KS_HALF : KS_DEAD;
      end else begin
        if (key_data == KEY_B) begin
          lock <= 1'b0;
          st   <= KS_IDLE;
        end else begin
          st <= KS_DEAD;
        end
      end
    end
  end

  assign fault = (st == KS_DEAD);

  // R2/R3/R4: a lock opens only on the cycle after its second key word
  p_open_needs_key_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(lock) |-> ($past(key_we) && $past(key_data) == KEY_B && $past(allow)));

  // R5: a dead sequence never lets its lock open
  p_dead_keeps_lock_r5: assert property (@(posedge clk) disable iff (rst)
    fault |=> lock);

  // R5: fault is sticky until reset
  p_fault_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    fault |=> fault);

endmodule

// File: rtl/flash_ctl_reg.sv
module flash_ctl_reg
  import flash_keyreg_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      wr,
  input  ctl_bits_t wbits,
  input  logic      lock_ctl,
  input  logic      lock_prog,
  output ctl_bits_t bits
);

  logic open_low;
  logic open_high;

  assign open_low  = !lock_ctl;
  assign open_high = !lock_ctl && !lock_prog;

  always_ff @(posedge clk) begin
    if (rst) begin
      bits <= '0;
    end else if (wr) begin
      if (open_low) begin
        bits.data_sel   <= wbits.data_sel;
        bits.fixed_time <= wbits.fixed_time;
      end
      if (open_high) begin
        bits.prg_en    <= wbits.prg_en;
        bits.erase     <= wbits.erase;
        bits.half_page <= wbits.half_page;
      end
    end
  end

  // R7: bits under the control lock hold while it is set
  p_low_guard_r7: assert property (@(posedge clk) disable iff (rst)
    lock_ctl |=> ($stable(bits.data_sel) && $stable(bits.fixed_time)));

  // R7: bits under the program lock hold while it is set
  p_high_guard_r7: assert property (@(posedge clk) disable iff (rst)
    lock_prog |=> ($stable(bits.prg_en) && $stable(bits.erase) && $stable(bits.half_page)));

endmodule

// File: rtl/flash_stat_reg.sv
module flash_stat_reg
  import flash_keyreg_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        clr_we,
  input  logic [31:0] clr_data,
  input  logic        busy_in,
  input  logic        ready_in,
  input  logic        eop_set,
  input  logic        wrperr_set,
  input  logic        pgaerr_set,
  input  logic        sizerr_set,
  output logic [31:0] stat_word
);

  localparam int NSTICKY = 4;
  localparam int STICKY_POS [NSTICKY] = '{SB_EOP, SB_WRPERR, SB_PGAERR, SB_SIZERR};

  logic               busy_q;
  logic               ready_q;
  logic [NSTICKY-1:0] sticky_q;
  logic [NSTICKY-1:0] set_v;

  assign set_v = {sizerr_set, pgaerr_set, wrperr_set, eop_set};

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      ready_q <= 1'b0;
    end else begin
      busy_q  <= busy_in;
      ready_q <= ready_in;
    end
  end

  for (genvar g = 0; g < NSTICKY; g++) begin : g_sticky
    always_ff @(posedge clk) begin
      if (rst)
        sticky_q[g] <= 1'b0;
      else if (set_v[g])
        sticky_q[g] <= 1'b1;
      else if (clr_we && clr_data[STICKY_POS[g]])
        sticky_q[g] <= 1'b0;
    end

    // R8: a flag stays set unless a one is written to it
    p_sticky_hold_r8: assert property (@(posedge clk) disable iff (rst)
      (sticky_q[g] && !(clr_we && clr_data[STICKY_POS[g]])) |=> sticky_q[g]);

    // R8: an event wins over a clear in the same cycle
    p_set_wins_r8: assert property (@(posedge clk) disable iff (rst)
      set_v[g] |=> sticky_q[g]);
  end

  always_comb begin
    stat_word = '0;
    stat_word[SB_BUSY]   = busy_q;
    stat_word[SB_READY]  = ready_q;
    stat_word[SB_EOP]    = sticky_q[0];
    stat_word[SB_WRPERR] = sticky_q[1];
    stat_word[SB_PGAERR] = sticky_q[2];
    stat_word[SB_SIZERR] = sticky_q[3];
  end

endmodule

// File: rtl/flash_keyreg_top.sv
module flash_keyreg_top
  import flash_keyreg_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [31:0]       bus_rdata,
  input  logic              seq_busy,
  input  logic              seq_ready,
  input  logic              seq_eop,
  input  logic              seq_wrperr,
  input  logic              seq_pgaerr,
  input  logic              seq_sizerr,
  output logic              lock_ctl,
  output logic              lock_prog,
  output logic              lock_opt,
  output logic              ctl_prg_en,
  output logic              ctl_data_sel,
  output logic              ctl_fixed_time,
  output logic              ctl_erase,
  output logic              ctl_half_page,
  output logic              key_fault
);

  logic                 hit_ctrl;
  logic                 hit_stat;
  logic                 wr_ctrl;
  logic [NUM_LOCKS-1:0] lock_v;
  logic [NUM_LOCKS-1:0] fault_v;
  logic [NUM_LOCKS-1:0] allow_v;
  ctl_bits_t            ctl_q;
  ctl_bits_t            ctl_w;
  logic [31:0]          ctl_word;
  logic [31:0]          stat_word;

  assign hit_ctrl = (bus_addr == ADDR_W'(OFF_CTRL));
  assign hit_stat = (bus_addr == ADDR_W'(OFF_STAT));
  assign wr_ctrl  = bus_we && hit_ctrl;

  // program key is honoured only with the control lock open
  always_comb begin
    allow_v          = '1;
    allow_v[LK_PROG] = !lock_v[LK_CTL];
  end

  for (genvar i = 0; i < NUM_LOCKS; i++) begin : g_lock
    flash_key_seq #(
      .KEY_A (KEY_FIRST[i]),
      .KEY_B (KEY_SECOND[i])
    ) u_seq (
      .clk      (clk),
      .rst      (rst),
      .key_we   (bus_we && bus_addr == ADDR_W'(KEY_OFF[i])),
      .key_data (bus_wdata),
      .allow    (allow_v[i]),
      .relock   (wr_ctrl && bus_wdata[i]),
      .lock     (lock_v[i]),
      .fault    (fault_v[i])
    );
  end

  assign ctl_w.prg_en     = bus_wdata[CB_PRG_EN];
  assign ctl_w.data_sel   = bus_wdata[CB_DATA_SEL];
  assign ctl_w.fixed_time = bus_wdata[CB_FIXED];
  assign ctl_w.erase      = bus_wdata[CB_ERASE];
  assign ctl_w.half_page  = bus_wdata[CB_HALF];

  flash_ctl_reg u_ctl (
    .clk       (clk),
    .rst       (rst),
    .wr        (wr_ctrl),
    .wbits     (ctl_w),
    .lock_ctl  (lock_v[LK_CTL]),
    .lock_prog (lock_v[LK_PROG]),
    .bits      (ctl_q)
  );

  flash_stat_reg u_stat (
    .clk        (clk),
    .rst        (rst),
    .clr_we     (bus_we && hit_stat),
    .clr_data   (bus_wdata),
    .busy_in    (seq_busy),
    .ready_in   (seq_ready),
    .eop_set    (seq_eop),
    .wrperr_set (seq_wrperr),
    .pgaerr_set (seq_pgaerr),
    .sizerr_set (seq_sizerr),
    .stat_word  (stat_word)
  );

  always_comb begin
    ctl_word                 = '0;
    ctl_word[NUM_LOCKS-1:0]  = lock_v;
    ctl_word[CB_PRG_EN]      = ctl_q.prg_en;
    ctl_word[CB_DATA_SEL]    = ctl_q.data_sel;
    ctl_word[CB_FIXED]       = ctl_q.fixed_time;
    ctl_word[CB_ERASE]       = ctl_q.erase;
    ctl_word[CB_HALF]        = ctl_q.half_page;
  end

  always_ff @(posedge clk) begin
    if (rst || !bus_re)
      bus_rdata <= '0;
    else if (hit_ctrl)
      bus_rdata <= ctl_word;
    else if (hit_stat)
      bus_rdata <= stat_word;
    else
      bus_rdata <= '0;
  end

  assign lock_ctl       = lock_v[LK_CTL];
  assign lock_prog      = lock_v[LK_PROG];
  assign lock_opt       = lock_v[LK_OPT];
  assign ctl_prg_en     = ctl_q.prg_en;
  assign ctl_data_sel   = ctl_q.data_sel;
  assign ctl_fixed_time = ctl_q.fixed_time;
  assign ctl_erase      = ctl_q.erase;
  assign ctl_half_page  = ctl_q.half_page;
  assign key_fault      = |fault_v;

  // R3: program lock opens only if the control lock was already open
  p_prog_after_ctl_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(lock_prog) |-> !$past(lock_ctl));

  // R6: writing one to a lock bit closes it on the next cycle
  p_relock_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_ctrl && bus_wdata[LK_CTL]) |=> lock_ctl);

  // R9: no read strobe, zero read data next cycle
  p_rdata_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !bus_re |=> (bus_rdata == 32'h0));

  // R5: key_fault never drops outside reset
  p_fault_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    $past(key_fault) |-> key_fault);

endmodule

// File: tb/flash_keyreg_top_tb_top.sv
module flash_keyreg_top_tb_top;

  localparam int ADDR_W = 8;
  localparam int NVEC   = 29;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [31:0]       bus_wdata = '0;
  logic              bus_we = 1'b0;
  logic              bus_re = 1'b0;
  logic [31:0]       bus_rdata;
  logic              seq_busy = 1'b0, seq_ready = 1'b0, seq_eop = 1'b0;
  logic              seq_wrperr = 1'b0, seq_pgaerr = 1'b0, seq_sizerr = 1'b0;
  logic              lock_ctl, lock_prog, lock_opt;
  logic              ctl_prg_en, ctl_data_sel, ctl_fixed_time, ctl_erase, ctl_half_page;
  logic              key_fault;

  int n_checks = 0;
  int n_errors = 0;

  always #10 clk = ~clk;  // 50 MHz

  flash_keyreg_top #(.ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .seq_busy(seq_busy), .seq_ready(seq_ready), .seq_eop(seq_eop),
    .seq_wrperr(seq_wrperr), .seq_pgaerr(seq_pgaerr), .seq_sizerr(seq_sizerr),
    .lock_ctl(lock_ctl), .lock_prog(lock_prog), .lock_opt(lock_opt),
    .ctl_prg_en(ctl_prg_en), .ctl_data_sel(ctl_data_sel),
    .ctl_fixed_time(ctl_fixed_time), .ctl_erase(ctl_erase),
    .ctl_half_page(ctl_half_page), .key_fault(key_fault)
  );

  // {is_read, req, addr, wdata, expected}
  localparam logic [76:0] VEC [NVEC] = '{
    {1'b1, 4'd1,  8'h04, 32'h0,        32'h00000007},
    {1'b1, 4'd1,  8'h18, 32'h0,        32'h00000000},
    {1'b0, 4'd7,  8'h04, 32'h00000718, 32'h0},
    {1'b1, 4'd7,  8'h04, 32'h0,        32'h00000007},
    {1'b0, 4'd2,  8'h08, 32'h89ABCDEF, 32'h0},
    {1'b0, 4'd2,  8'h08, 32'h02030405, 32'h0},
    {1'b1, 4'd2,  8'h04, 32'h0,        32'h00000006},
    {1'b0, 4'd7,  8'h04, 32'h0000071E, 32'h0},
    {1'b1, 4'd7,  8'h04, 32'h0,        32'h00000116},
    {1'b0, 4'd3,  8'h10, 32'h8C9DAEBF, 32'h0},
    {1'b0, 4'd3,  8'h10, 32'h13141516, 32'h0},
    {1'b1, 4'd3,  8'h04, 32'h0,        32'h00000114},
    {1'b0, 4'd7,  8'h04, 32'h0000071C, 32'h0},
    {1'b1, 4'd7,  8'h04, 32'h0,        32'h0000071C},
    {1'b0, 4'd4,  8'h14, 32'hFBEAD9C8, 32'h0},
    {1'b0, 4'd4,  8'h14, 32'h24252627, 32'h0},
    {1'b1, 4'd4,  8'h04, 32'h0,        32'h00000718},
    {1'b0, 4'd10, 8'h08, 32'h89ABCDEF, 32'h0},
    {1'b1, 4'd10, 8'h04, 32'h0,        32'h00000718},
    {1'b1, 4'd9,  8'h08, 32'h0,        32'h00000000},
    {1'b1, 4'd9,  8'h0C, 32'h0,        32'h00000000},
    {1'b0, 4'd6,  8'h04, 32'h00000002, 32'h0},
    {1'b1, 4'd6,  8'h04, 32'h0,        32'h00000002},
    {1'b0, 4'd6,  8'h10, 32'h8C9DAEBF, 32'h0},
    {1'b0, 4'd6,  8'h10, 32'h13141516, 32'h0},
    {1'b1, 4'd6,  8'h04, 32'h0,        32'h00000000},
    {1'b0, 4'd6,  8'h04, 32'h00000001, 32'h0},
    {1'b0, 4'd7,  8'h04, 32'h00000008, 32'h0},
    {1'b1, 4'd7,  8'h04, 32'h0,        32'h00000001}
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_re = 1'b1;
    @(negedge clk);
    bus_re = 1'b0;
    d = bus_rdata;
  endtask

  task automatic rd_check(input logic [7:0] a, input logic [31:0] exp, input string req);
    logic [31:0] v;
    rd(a, v);
    check(v == exp, req, v, exp);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
    $finish;
  end

  initial begin : main
    do_reset();
    check({lock_ctl, lock_prog, lock_opt} == 3'b111 && !key_fault, "R1",
          {28'h0, lock_ctl, lock_prog, lock_opt, key_fault}, 32'hE);

    for (int i = 0; i < NVEC; i++) begin
      logic [76:0] v;
      v = VEC[i];
      if (v[76]) begin
        logic [31:0] got;
        rd(v[71:64], got);
        check(got == v[31:0], $sformatf("R%0d vec%0d", v[75:72], i), got, v[31:0]);
      end else begin
        wr(v[71:64], v[63:32]);
      end
    end

    // R10: key write to an open lock did not raise a fault
    check(!key_fault, "R10", {31'h0, key_fault}, 32'h0);
    // R7: ports follow the control word
    check({ctl_prg_en, ctl_data_sel, ctl_fixed_time, ctl_erase, ctl_half_page} == 5'b0 && lock_ctl,
          "R7", {26'h0, lock_ctl, ctl_prg_en, ctl_data_sel, ctl_fixed_time, ctl_erase, ctl_half_page},
          32'h20);
    // R9: idle read data
    @(negedge clk);
    check(bus_rdata == 32'h0, "R9", bus_rdata, 32'h0);

    // R5: wrong value, then the right pair is refused
    do_reset();
    wr(8'h08, 32'h12345678);
    check(key_fault, "R5", {31'h0, key_fault}, 32'h1);
    wr(8'h08, 32'h89ABCDEF);
    wr(8'h08, 32'h02030405);
    rd_check(8'h04, 32'h00000007, "R5");

    // R5: second key first
    do_reset();
    check(!key_fault, "R1", {31'h0, key_fault}, 32'h0);
    wr(8'h08, 32'h02030405);
    check(key_fault, "R5", {31'h0, key_fault}, 32'h1);

    // R3: program key before control unlock
    do_reset();
    wr(8'h10, 32'h8C9DAEBF);
    check(key_fault, "R3", {31'h0, key_fault}, 32'h1);
    wr(8'h08, 32'h89ABCDEF);
    wr(8'h08, 32'h02030405);
    wr(8'h10, 32'h8C9DAEBF);
    wr(8'h10, 32'h13141516);
    rd_check(8'h04, 32'h00000006, "R3");

    // R8: status flags
    do_reset();
    @(negedge clk);
    seq_busy = 1'b1; seq_ready = 1'b1; seq_eop = 1'b1; seq_pgaerr = 1'b1;
    @(negedge clk);
    seq_eop = 1'b0; seq_pgaerr = 1'b0;
    rd_check(8'h18, 32'h0000020B, "R8");
    wr(8'h18, 32'h00000002);
    rd_check(8'h18, 32'h00000209, "R8");
    @(negedge clk);
    bus_addr = 8'h18; bus_wdata = 32'h00000400; bus_we = 1'b1; seq_sizerr = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; seq_sizerr = 1'b0;
    rd_check(8'h18, 32'h00000609, "R8");
    seq_busy = 1'b0; seq_ready = 1'b0;
    wr(8'h18, 32'h00000702);
    rd_check(8'h18, 32'h00000000, "R8");

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule